// File: doc/BRIEF.md
# Four-level priority interrupt controller

This block collects interrupt requests for a small 8-bit processor core and tells the core when to force a call to a service routine. It handles eleven sources: seven external lines, three timer overflow lines and one serial channel line. Each source has a request flag, an individual enable and a two-bit priority level. A global enable masks all of them.

The source indices are fixed, and a lower index wins a tie: 0 external line 0, 1 timer 0, 2 external line 1, 3 timer 1, 4 serial, 5..9 external lines 2..6, 10 timer 2. Inputs are captured into flags at one clock edge. The winning request is registered at the next edge. The call strobe `vec_req` is then raised combinationally whenever the core may accept it. The core treats a cycle with `vec_req` high as the acknowledge and branches to the vector of `vec_idx`. A four-bit in-service mask records which levels are being serviced, and a return-from-interrupt pulse (`reti_exec`) closes the innermost one.

The register port is a byte-wide port with seven addresses:

| Address | Contents |
|---|---|
| 0 | Mask A |
| 1 | Mask B |
| 2 | Mask C |
| 3 | Level-low register, bits 7:0 |
| 4 | Level-low register, bits 10:8 |
| 5 | Level-high register, bits 7:0 |
| 6 | Level-high register, bits 10:8 |

Address 7 is unassigned and reads 0.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every register address reads 0 and `vec_req` is low.
- R2: Register layout:
  - Mask A: bit 7 is the global enable, bit 6 is a stored spare bit, bit 5 always reads 0, and bits 4..0 enable sources 4..0.
  - Mask B: bits 4..0 enable sources 9..5.
  - Mask C: bit 0 enables source 10.
  - Source i's level is {level-high[i], level-low[i]}.
  - Unimplemented bits read 0.
- R3: A flag is captured whether or not its source is enabled. A source flagged while masked raises `vec_req` once it is enabled.
- R4: A level-type input first sampled high at clock edge k, with all gates open, gives `vec_req` high in the cycle after edge k+1, and not in the cycle after edge k.
- R5: No call is requested while the global enable is 0 or the source's own enable is 0.
- R6: `vec_req` stays low when any of these holds:
  - `instr_done` is low.
  - `reti_exec` is high.
  - The current cycle writes one of addresses 0..6.
  - The previous cycle wrote one of addresses 0..6.
  A write to address 7 does not hold the call off.
- R7: Among pending enabled sources, the highest level wins. Ties go to the lowest source index.
- R8: A request is acknowledged only if its level is strictly above every level in service. An equal-level request waits, and a higher one pre-empts.
- R9: `reti_exec` clears only the highest set bit of the in-service mask, so lower levels stay blocking.
- R10: Edge-type sources set their flag on a rising input and clear it when acknowledged, so a held input calls once. Level-type flags follow the input, so a held input calls again after RETI. By default sources 0,1,2,3,10 are edge type and 4..9 are level type.
- R11: Bit 6 of mask A has no effect on interrupt requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_irq | input | 7 | External request lines 0..6 |
| tmr_ovf | input | 3 | Timer 0, 1, 2 overflow lines |
| ser_irq | input | 1 | Serial channel request |
| instr_done | input | 1 | Core is completing the current instruction this cycle |
| reti_exec | input | 1 | Core executes a return-from-interrupt this cycle |
| cfg_we | input | 1 | Register write strobe from the core |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data for `cfg_addr` |
| vec_req | output | 1 | Force-call strobe; high cycle is the acknowledge |
| vec_idx | output | 4 | Winning source index, valid while `vec_req` is high |

## Verification
Four properties are checked on every cycle:
- A call never issues without the global enable.
- A protected register write always suppresses the call in the following cycle.
- Every acknowledge adds a level that was not already in service.
- A RETI removes exactly one in-service level, and an acknowledged edge flag is cleared.

Other behaviours are shown only by the bench's scenarios:
- Fixed index order among equal levels.
- Which in-service bit RETI removes.
- The exact two-edge request latency.
- A flag captured while masked.
- The different re-triggering of held edge and level inputs.

// File: rtl/irqc_pkg.sv
// Shared constants and types of the priority interrupt controller.
// Assumes a fixed set of eleven sources and a byte-wide register port.
package irqc_pkg;
    localparam int NSRC = 11;            // number of request sources
    localparam int NLVL = 4;             // number of priority levels
    localparam int LVLW = $clog2(NLVL);  // bits of one level
    localparam int IDXW = $clog2(NSRC);  // bits of a source index
    localparam int DW   = 8;             // register data width
    localparam int AW   = 3;             // register address width

    typedef logic [NSRC-1:0] src_vec_t;
    typedef logic [LVLW-1:0] lvl_t;
    typedef logic [LVLW:0]   depth_t;    // 0 = nothing in service, else level+1
    typedef logic [IDXW-1:0] idx_t;
    typedef logic [DW-1:0]   byte_t;
    typedef logic [AW-1:0]   addr_t;

    localparam addr_t A_MASK_A = 3'd0;
    localparam addr_t A_MASK_B = 3'd1;
    localparam addr_t A_MASK_C = 3'd2;
    localparam addr_t A_LLO_L  = 3'd3;
    localparam addr_t A_LLO_H  = 3'd4;
    localparam addr_t A_LHI_L  = 3'd5;
    localparam addr_t A_LHI_H  = 3'd6;

    // Width of the upper part of a level register (bits 10:8).
    localparam int HIW = NSRC - DW;
endpackage

// File: rtl/irqc_cfg.sv
// Enable and priority registers of the interrupt controller.
// Holds three mask registers and two level registers split over byte addresses,
// and flags any write that touches them (protected write).
// Assumes a synchronous active-low reset and combinational read data.
module irqc_cfg
    import irqc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     we,
    input  addr_t    addr,
    input  byte_t    wdata,
    output byte_t    rdata,
    output logic     glob_en,
    output src_vec_t src_en,
    output src_vec_t lvl_lo,
    output src_vec_t lvl_hi,
    output logic     prot_wr
);
    localparam int NB = 5;      // sources served by mask B

    byte_t          mask_a_q;
    logic [NB-1:0]  mask_b_q;
    logic           mask_c_q;
    src_vec_t       llo_q;
    src_vec_t       lhi_q;

    // Register write port; bit 5 of mask A is not stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_a_q <= '0;
            mask_b_q <= '0;
            mask_c_q <= 1'b0;
            llo_q    <= '0;
            lhi_q    <= '0;
        end else if (we) begin
            case (addr)
                A_MASK_A: mask_a_q <= wdata & 8'hDF;
                A_MASK_B: mask_b_q <= wdata[NB-1:0];
                A_MASK_C: mask_c_q <= wdata[0];
                A_LLO_L:  llo_q[DW-1:0]    <= wdata;
                A_LLO_H:  llo_q[NSRC-1:DW] <= wdata[HIW-1:0];
                A_LHI_L:  lhi_q[DW-1:0]    <= wdata;
                A_LHI_H:  lhi_q[NSRC-1:DW] <= wdata[HIW-1:0];
                default:  ;
            endcase
        end
    end

    // Read multiplexer; unimplemented bits read as zero.
    always_comb begin
        case (addr)
            A_MASK_A: rdata = mask_a_q;
            A_MASK_B: rdata = byte_t'(mask_b_q);
            A_MASK_C: rdata = byte_t'(mask_c_q);
            A_LLO_L:  rdata = llo_q[DW-1:0];
            A_LLO_H:  rdata = byte_t'(llo_q[NSRC-1:DW]);
            A_LHI_L:  rdata = lhi_q[DW-1:0];
            A_LHI_H:  rdata = byte_t'(lhi_q[NSRC-1:DW]);
            default:  rdata = '0;
        endcase
    end

    // Source enable vector in index order, plus the global gate.
    assign src_en  = {mask_c_q, mask_b_q, mask_a_q[4:0]};
    assign glob_en = mask_a_q[7];
    assign lvl_lo  = llo_q;
    assign lvl_hi  = lhi_q;
    assign prot_wr = we && (addr <= A_LHI_H);
endmodule

// File: rtl/irqc_flags.sv
// Request flag capture. Each source is either edge type (set on a rising
// input, cleared by its acknowledge) or level type (a registered copy of
// the input), selected per bit by EDGE_MASK.
// Assumes clr is one-hot or zero.
module irqc_flags
    import irqc_pkg::*;
#(
    parameter src_vec_t EDGE_MASK = 11'b100_0000_1111
) (
    input  logic     clk,
    input  logic     rst_n,
    input  src_vec_t src_in,
    input  src_vec_t clr,
    output src_vec_t flag
);
    src_vec_t prev_q;
    src_vec_t flag_q;

    // Previous input sample for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= src_in;
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        if (EDGE_MASK[i]) begin : g_edge
            // Edge flag: a new rising edge wins over a same-cycle clear.
            always_ff @(posedge clk) begin
                if (!rst_n) flag_q[i] <= 1'b0;
                else        flag_q[i] <= (src_in[i] && !prev_q[i]) || (flag_q[i] && !clr[i]);
            end

            p_edge_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
                (clr[i] && !(src_in[i] && !prev_q[i])) |=> !flag_q[i]);
        end else begin : g_level
            // Level flag: follows the sampled input.
            always_ff @(posedge clk) begin
                if (!rst_n) flag_q[i] <= 1'b0;
                else        flag_q[i] <= src_in[i];
            end
        end
    end

    assign flag = flag_q;
endmodule

// File: rtl/irqc_arb.sv
// Priority resolution. Picks, among flagged and enabled sources, the one
// with the highest level and, on a tie, the lowest index, then registers it
// as the pending request (the poll stage).
module irqc_arb
    import irqc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  src_vec_t flag,
    input  src_vec_t src_en,
    input  logic     glob_en,
    input  src_vec_t lvl_lo,
    input  src_vec_t lvl_hi,
    output logic     pend_v,
    output idx_t     pend_idx,
    output lvl_t     pend_lvl
);
    logic best_v;
    idx_t best_idx;
    lvl_t best_lvl;

    // Linear scan: strict compare keeps the lowest index among equal levels.
    always_comb begin
        best_v   = 1'b0;
        best_idx = '0;
        best_lvl = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (glob_en && flag[i] && src_en[i] &&
                (!best_v || lvl_t'({lvl_hi[i], lvl_lo[i]}) > best_lvl)) begin
                best_v   = 1'b1;
                best_idx = idx_t'(i);
                best_lvl = lvl_t'({lvl_hi[i], lvl_lo[i]});
            end
        end
    end

    // Poll register holding the current winner.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v   <= 1'b0;
            pend_idx <= '0;
            pend_lvl <= '0;
        end else begin
            pend_v   <= best_v;
            pend_idx <= best_idx;
            pend_lvl <= best_lvl;
        end
    end
endmodule

// File: rtl/irqc_isr.sv
// In-service level mask. An acknowledge sets the bit of its level; a
// return-from-interrupt clears the highest set bit. Also reports the
// current service depth as highest level + 1 (0 when idle).
// Assumes push and pop are never high together.
module irqc_isr
    import irqc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  lvl_t            push_lvl,
    input  logic            pop,
    output logic [NLVL-1:0] isr,
    output depth_t          cur_lvl
);
    logic [NLVL-1:0] isr_q;
    logic [NLVL-1:0] top_bit;

    // Locate the highest in-service level.
    always_comb begin
        cur_lvl = '0;
        top_bit = '0;
        for (int j = 0; j < NLVL; j++) begin
            if (isr_q[j]) begin
                cur_lvl = depth_t'(j + 1);
                top_bit = NLVL'(1) << j;
            end
        end
    end

    // Mask update on acknowledge and on return.
    always_ff @(posedge clk) begin
        if (!rst_n)    isr_q <= '0;
        else if (push) isr_q <= isr_q | (NLVL'(1) << push_lvl);
        else if (pop)  isr_q <= isr_q & ~top_bit;
    end

    assign isr = isr_q;

    p_push_new_r8: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (isr_q & ~$past(isr_q)) != '0);

    p_pop_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && isr_q != '0) |=> $countones(isr_q) == $countones($past(isr_q)) - 1);
endmodule

// File: rtl/prio_irq_ctrl.sv
// Top of the four-level priority interrupt controller.
// Maps the request lines to fixed source indices, chains flag capture,
// resolution and the in-service mask, and gates the force-call strobe by
// the core handshake: instruction completing, no RETI, no protected write
// in this or the previous cycle, and a level above the one in service.
module prio_irq_ctrl
    import irqc_pkg::*;
#(
    parameter src_vec_t EDGE_MASK = 11'b100_0000_1111
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [6:0] ext_irq,
    input  logic [2:0] tmr_ovf,
    input  logic       ser_irq,
    input  logic       instr_done,
    input  logic       reti_exec,
    input  logic       cfg_we,
    input  logic [2:0] cfg_addr,
    input  logic [7:0] cfg_wdata,
    output logic [7:0] cfg_rdata,
    output logic       vec_req,
    output logic [3:0] vec_idx
);
    src_vec_t        src_in, flag, src_en, lvl_lo, lvl_hi, clr;
    logic            glob_en, prot_wr, prot_q;
    logic            pend_v;
    idx_t            pend_idx;
    lvl_t            pend_lvl;
    logic [NLVL-1:0] isr;
    depth_t          cur_lvl;
    logic            gate_ok;

    // Fixed source order: index decides ties.
    assign src_in = {tmr_ovf[2], ext_irq[6:2], ser_irq, tmr_ovf[1],
                     ext_irq[1], tmr_ovf[0], ext_irq[0]};

    irqc_cfg i_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .addr    (cfg_addr),
        .wdata   (cfg_wdata),
        .rdata   (cfg_rdata),
        .glob_en (glob_en),
        .src_en  (src_en),
        .lvl_lo  (lvl_lo),
        .lvl_hi  (lvl_hi),
        .prot_wr (prot_wr)
    );

    irqc_flags #(.EDGE_MASK(EDGE_MASK)) i_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_in (src_in),
        .clr    (clr),
        .flag   (flag)
    );

    irqc_arb i_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .flag     (flag),
        .src_en   (src_en),
        .glob_en  (glob_en),
        .lvl_lo   (lvl_lo),
        .lvl_hi   (lvl_hi),
        .pend_v   (pend_v),
        .pend_idx (pend_idx),
        .pend_lvl (pend_lvl)
    );

    irqc_isr i_isr (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (vec_req),
        .push_lvl (pend_lvl),
        .pop      (reti_exec),
        .isr      (isr),
        .cur_lvl  (cur_lvl)
    );

    // Remember a protected write so the stale poll result is not used.
    always_ff @(posedge clk) begin
        if (!rst_n) prot_q <= 1'b0;
        else        prot_q <= prot_wr;
    end

    // Handshake and nesting gate for the force-call strobe.
    always_comb begin
        gate_ok = instr_done && !reti_exec && !prot_wr && !prot_q &&
                  (({1'b0, pend_lvl} + depth_t'(1)) > cur_lvl);
        vec_req = pend_v && gate_ok;
        vec_idx = pend_idx;
        clr     = vec_req ? (src_vec_t'(1) << pend_idx) : '0;
    end

    p_req_global_r5: assert property (@(posedge clk) disable iff (!rst_n)
        vec_req |-> glob_en);

    p_holdoff_r6: assert property (@(posedge clk) disable iff (!rst_n)
        prot_wr |=> !vec_req);

    p_level_known_r8: assert property (@(posedge clk) disable iff (!rst_n)
        vec_req |-> !isr[pend_lvl]);
endmodule

// File: tb/test_prio_irq_ctrl.sv
// Self-checking bench: directed corner cases plus seeded random priority
// contests among the level-type sources.
module test_prio_irq_ctrl;
    localparam int CLK_NS = 10;
    localparam int WD_CYC = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] ext_irq = '0;
    logic [2:0] tmr_ovf = '0;
    logic       ser_irq = 1'b0;
    logic       instr_done = 1'b0;
    logic       reti_exec = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       vec_req;
    logic [3:0] vec_idx;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #(CLK_NS/2) clk = ~clk;

    prio_irq_ctrl i_prio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .ext_irq(ext_irq), .tmr_ovf(tmr_ovf),
        .ser_irq(ser_irq), .instr_done(instr_done), .reti_exec(reti_exec),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .vec_req(vec_req), .vec_idx(vec_idx)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg_wr(input logic [2:0] a, input logic [7:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a, input logic [7:0] exp);
        cfg_addr = a;
        #1;
        chk(tag, cfg_rdata, exp);
    endtask

    task automatic req_chk(input string tag, input logic exp_v, input logic [3:0] exp_i);
        #1;
        chk(tag, vec_req, exp_v);
        if (exp_v) chk(tag, vec_idx, exp_i);
    endtask

    // Reference winner: highest level, lowest index among equals. {valid, index}.
    function automatic logic [4:0] ref_pick(input logic [10:0] act, input logic [10:0] lo,
                                            input logic [10:0] hi);
        logic v = 1'b0;
        logic [3:0] bi = '0;
        logic [1:0] bl = '0;
        for (int i = 0; i < 11; i++) begin
            if (act[i] && (!v || {hi[i], lo[i]} > bl)) begin
                v = 1'b1; bi = 4'(i); bl = {hi[i], lo[i]};
            end
        end
        return {v, bi};
    endfunction

    initial begin
        repeat (WD_CYC) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        @(negedge clk);
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1: reset state
        for (int a = 0; a < 8; a++) rd_chk("R1 reset read", 3'(a), 8'h00);
        req_chk("R1 reset vec_req", 1'b0, 4'd0);

        // R2: register layout and unused bits
        cfg_wr(3'd0, 8'hFF); rd_chk("R2 mask A", 3'd0, 8'hDF);
        cfg_wr(3'd1, 8'hFF); rd_chk("R2 mask B", 3'd1, 8'h1F);
        cfg_wr(3'd2, 8'hFF); rd_chk("R2 mask C", 3'd2, 8'h01);
        cfg_wr(3'd3, 8'hA5); rd_chk("R2 level low L", 3'd3, 8'hA5);
        cfg_wr(3'd4, 8'hFF); rd_chk("R2 level low H", 3'd4, 8'h07);
        cfg_wr(3'd6, 8'hFA); rd_chk("R2 level high H", 3'd6, 8'h02);
        cfg_wr(3'd7, 8'hFF); rd_chk("R2 unassigned", 3'd7, 8'h00);
        for (int a = 0; a < 7; a++) cfg_wr(3'(a), 8'h00);

        // R11/R5/R3: spare bit set, global off; flag captured while masked
        cfg_wr(3'd0, 8'h41); rd_chk("R11 spare bit stored", 3'd0, 8'h41);
        instr_done = 1'b1;
        ext_irq[0] = 1'b1; tick(); ext_irq[0] = 1'b0;
        repeat (3) tick();
        req_chk("R11 R5 spare bit and no global", 1'b0, 4'd0);
        cfg_wr(3'd0, 8'h81);
        req_chk("R6 cycle after protected write", 1'b0, 4'd0);
        tick();
        req_chk("R3 masked flag fires on enable", 1'b1, 4'd0);
        tick();
        req_chk("R8 no re-entry same level", 1'b0, 4'd0);
        reti_exec = 1'b1; tick(); reti_exec = 1'b0;
        tick(); tick();
        req_chk("R10 edge flag cleared by ack", 1'b0, 4'd0);

        // R4/R10: held edge-type timer 0 calls once, two-edge latency
        cfg_wr(3'd0, 8'h82); tick();
        tmr_ovf[0] = 1'b1;
        tick();
        req_chk("R4 not after first edge", 1'b0, 4'd0);
        tick();
        req_chk("R4 request after second edge", 1'b1, 4'd1);
        tick();
        reti_exec = 1'b1; tick(); reti_exec = 1'b0;
        repeat (3) tick();
        req_chk("R10 held edge input no retrigger", 1'b0, 4'd0);
        tmr_ovf[0] = 1'b0;

        // R6: hold-off conditions with level-type serial source
        cfg_wr(3'd0, 8'h90);
        instr_done = 1'b0; ser_irq = 1'b1;
        repeat (3) tick();
        req_chk("R6 instruction not done", 1'b0, 4'd0);
        instr_done = 1'b1; reti_exec = 1'b1;
        req_chk("R6 RETI in progress", 1'b0, 4'd0);
        tick();
        reti_exec = 1'b0; cfg_we = 1'b1; cfg_addr = 3'd3; cfg_wdata = 8'h00;
        req_chk("R6 protected write", 1'b0, 4'd0);
        tick();
        cfg_we = 1'b0;
        req_chk("R6 cycle after write", 1'b0, 4'd0);
        tick();
        cfg_we = 1'b1; cfg_addr = 3'd7;
        req_chk("R6 unassigned write no hold", 1'b1, 4'd4);
        tick();
        cfg_we = 1'b0;
        req_chk("R8 equal level while in service", 1'b0, 4'd0);
        reti_exec = 1'b1; tick(); reti_exec = 1'b0;
        req_chk("R10 held level input re-requests", 1'b1, 4'd4);
        instr_done = 1'b0;
        ser_irq = 1'b0;
        repeat (3) tick();
        instr_done = 1'b1;
        req_chk("R10 level flag follows input", 1'b0, 4'd0);

        // R7/R8/R9: ties, pre-emption, selective return
        instr_done = 1'b0;
        cfg_wr(3'd1, 8'h07);
        cfg_wr(3'd3, 8'h70);
        cfg_wr(3'd5, 8'hC0);
        ser_irq = 1'b1; ext_irq[2] = 1'b1;
        repeat (3) tick();
        instr_done = 1'b1;
        req_chk("R7 tie goes to lower index", 1'b1, 4'd4);
        tick();
        req_chk("R8 equal level waits", 1'b0, 4'd0);
        ext_irq[3] = 1'b1;
        tick();
        req_chk("R4 latency on pre-empting source", 1'b0, 4'd0);
        tick();
        req_chk("R8 higher level pre-empts", 1'b1, 4'd6);
        tick();
        req_chk("R8 nested level busy", 1'b0, 4'd0);
        ext_irq[3] = 1'b0;
        tick(); tick();
        reti_exec = 1'b1; tick(); reti_exec = 1'b0;
        ext_irq[4] = 1'b1;
        tick(); tick();
        req_chk("R9 RETI keeps lower level", 1'b1, 4'd7);
        instr_done = 1'b0;
        ser_irq = 1'b0; ext_irq = '0;
        reti_exec = 1'b1; tick(); reti_exec = 1'b0;
        repeat (3) tick();

        // R7/R5: seeded random contests among level-type sources 4..9
        for (int it = 0; it < 40; it++) begin
            logic [10:0] lo, hi, en, lines;
            logic [4:0]  pick;
            lo = '0; hi = '0; en = '0; lines = '0;
            lo[9:4] = 6'($urandom); hi[9:4] = 6'($urandom);
            en[9:4] = 6'($urandom); lines[9:4] = 6'($urandom);
            cfg_wr(3'd0, {3'b100, en[4], 4'b0000});
            cfg_wr(3'd1, {3'b000, en[9:5]});
            cfg_wr(3'd3, lo[7:0]); cfg_wr(3'd4, {5'd0, lo[10:8]});
            cfg_wr(3'd5, hi[7:0]); cfg_wr(3'd6, {5'd0, hi[10:8]});
            ser_irq = lines[4]; ext_irq[6:2] = lines[9:5];
            repeat (3) tick();
            req_chk("R6 random hold while busy", 1'b0, 4'd0);
            pick = ref_pick(lines & en, lo, hi);
            instr_done = 1'b1;
            req_chk("R7 R5 random winner", pick[4], pick[3:0]);
            tick();
            instr_done = 1'b0; ser_irq = 1'b0; ext_irq = '0;
            reti_exec = 1'b1; tick(); reti_exec = 1'b0;
            repeat (3) tick();
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule